// File: doc/BRIEF.md
# Fixed-Latency Memory Read Adapter

This block places a synchronous read-only memory with a fixed multi-cycle read latency behind a decoupled request/response interface. A caller issues a read by presenting an address with `req_valid_i` while `req_ready_o` is high. Later it inspects the oldest returned word through `resp_valid_o`/`resp_data_o` and consumes it with `resp_deq_i`. The memory pipeline never stalls. Every word it returns is captured in a small response FIFO.

A credit counter makes this safe. It counts every request that has been accepted and whose response has not yet been dequeued, whether that response is still in the memory pipeline or already sitting in the FIFO. Requests are accepted only while the count is below the FIFO depth, so the FIFO cannot overflow. The caller may therefore leave responses unconsumed for as long as it likes. A valid bit travels beside the memory's data pipeline, so only cycles that carry real data are written into the FIFO. The memory contents are a fixed computed pattern.

Top module: `mrw_top`

## Requirements
- R1: While `rst_ni` is low and right after it is released, `req_ready_o` is 1 and `resp_valid_o` is 0. Any request that was in flight when reset was asserted produces no response.
- R2: The outstanding count is the number of accepted requests minus the number of effective dequeues. `req_ready_o` is 1 exactly when this count is below DEPTH (default 5). The value of `resp_deq_i` in the same cycle does not affect `req_ready_o`.
- R3: Every accepted request produces exactly one response. Responses are presented in the order the requests were accepted, and none is lost however long the caller stalls.
- R4: If no older response is pending, a request accepted on rising edge e makes `resp_valid_o` 1 right after edge e+LAT (default LAT = 3). `resp_valid_o` is 1 exactly while at least one returned word is buffered.
- R5: The response data for address a is the low DATA_W bits of a*0x9E37 + 0x1234, computed with 32-bit arithmetic.
- R6: While `resp_valid_o` is 1 and `resp_deq_i` is 0, `resp_valid_o` stays 1 and `resp_data_o` holds its value on every following cycle. This holds even while further responses arrive behind the oldest one.
- R7: A request presented while `req_ready_o` is 0 is ignored. It leaves the count unchanged and produces no response.
- R8: `resp_deq_i` asserted while `resp_valid_o` is 0 is ignored. It leaves the count unchanged and takes nothing from the FIFO.
- R9: When a request is accepted and a response is dequeued on the same edge, the count is unchanged. With DEPTH ≥ LAT+2, a caller that requests and dequeues every cycle has `req_ready_o` held at 1 in steady state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request present |
| req_addr_i | input | ADDR_W | Read address |
| req_ready_o | output | 1 | Request will be accepted this cycle |
| resp_valid_o | output | 1 | Oldest response available |
| resp_data_o | output | DATA_W | Oldest response word (peek) |
| resp_deq_i | input | 1 | Consume the oldest response |

## Verification
A bench-side model, built from the requirements, predicts ready, valid and data every cycle under several stimulus patterns. A request burst with no dequeues shows where credits run out and which requests are rejected. An idle stall followed by a drain separates buffered data from in-flight data, and also exercises dequeues on an empty buffer. Requests and dequeues issued together in every cycle reveal whether simultaneous accept and release keep the count steady and sustain one request per cycle. A single isolated request measures the exact latency. A long stall with a full buffer shows whether the held word stays stable. A reset asserted while reads are in flight shows whether those reads are discarded.

// File: rtl/mrw_pkg.sv
`timescale 1ns/1ps
package mrw_pkg;
  localparam logic [31:0] ROM_MUL = 32'h0000_9E37;
  localparam logic [31:0] ROM_ADD = 32'h0000_1234;

  // fixed memory image: one word per address
  function automatic logic [31:0] rom_word(input logic [31:0] addr);
    return addr * ROM_MUL + ROM_ADD;
  endfunction
endpackage

// File: rtl/mrw_credit.sv
`timescale 1ns/1ps
module mrw_credit #(
  parameter int DEPTH = 5,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          give_i,
  output logic          ready_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case ({take_i, give_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;  // both or neither: net zero
      endcase
    end
  end

  assign ready_o = (cnt_q < CW'(DEPTH));
  assign cnt_o   = cnt_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R2
  AST_NO_GIVE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    give_i |-> cnt_q != '0); // R8
endmodule

// File: rtl/mrw_lat_pipe.sv
`timescale 1ns/1ps
module mrw_lat_pipe #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LAT    = 3,
  localparam int WORDS = 2 ** ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o,
  output logic [LAT-1:0]    vld_vec_o
);
  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] dat_q [LAT];
  logic [LAT-1:0]    vld_q;

  for (genvar i = 0; i < WORDS; i++) begin : g_rom
    assign mem[i] = DATA_W'(mrw_pkg::rom_word(32'(i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q[0] <= 1'b0;
      dat_q[0] <= '0;
    end else begin
      vld_q[0] <= req_i;
      if (req_i) dat_q[0] <= mem[addr_i];
    end
  end

  for (genvar k = 1; k < LAT; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[k] <= 1'b0;
        dat_q[k] <= '0;
      end else begin
        vld_q[k] <= vld_q[k-1];
        dat_q[k] <= dat_q[k-1];
      end
    end
  end

  assign vld_o     = vld_q[LAT-1];
  assign data_o    = dat_q[LAT-1];
  assign vld_vec_o = vld_q;
endmodule

// File: rtl/mrw_resp_fifo.sv
`timescale 1ns/1ps
module mrw_resp_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 5,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CW-1:0]     cnt_o
);
  logic [DATA_W-1:0] buf_q [DEPTH];
  logic [PW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     cnt_q;
  logic              full;

  assign full = (cnt_q == CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_i) wr_ptr_q <= (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + PW'(1);
      if (rd_i) rd_ptr_q <= (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + PW'(1);
      unique case ({wr_i, rd_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) buf_q[wr_ptr_q] <= wr_data_i;
  end

  assign valid_o = (cnt_q != '0);
  assign data_o  = buf_q[rd_ptr_q];
  assign cnt_o   = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !full); // R3
  AST_HEAD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !rd_i |=> valid_o && $stable(data_o)); // R6
endmodule

// File: rtl/mrw_top.sv
`timescale 1ns/1ps
module mrw_top #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LAT    = 3,
  parameter int DEPTH  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              resp_valid_o,
  output logic [DATA_W-1:0] resp_data_o,
  input  logic              resp_deq_i
);
  localparam int CW = $clog2(DEPTH + 1);

  logic              accept, deq;
  logic [CW-1:0]     credit_cnt, fifo_cnt;
  logic              pipe_vld;
  logic [DATA_W-1:0] pipe_data;
  logic [LAT-1:0]    pipe_vec;

  assign accept = req_valid_i & req_ready_o;
  assign deq    = resp_deq_i & resp_valid_o;

  mrw_credit #(.DEPTH(DEPTH)) u_credit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (accept),
    .give_i  (deq),
    .ready_o (req_ready_o),
    .cnt_o   (credit_cnt)
  );

  mrw_lat_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT)) u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (accept),
    .addr_i    (req_addr_i),
    .vld_o     (pipe_vld),
    .data_o    (pipe_data),
    .vld_vec_o (pipe_vec)
  );

  mrw_resp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (pipe_vld),
    .wr_data_i (pipe_data),
    .rd_i      (deq),
    .valid_o   (resp_valid_o),
    .data_o    (resp_data_o),
    .cnt_o     (fifo_cnt)
  );

  // credits must equal words in flight plus words buffered
  AST_CREDIT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(credit_cnt) == 32'(fifo_cnt) + $countones(pipe_vec)); // R3
  AST_VALID_NEEDS_CREDIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !req_ready_o || (credit_cnt != '0)); // R2
endmodule

// File: tb/mrw_top_bench.sv
`timescale 1ns/1ps
module mrw_top_bench;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int LAT    = 3;
  localparam int DEPTH  = 5;
  localparam int NVEC   = 32;

  // {req_valid, deq, addr}
  localparam logic [9:0] VEC [NVEC] = '{
    10'h201, 10'h202, 10'h203, 10'h204, 10'h205, 10'h206, 10'h207,
    10'h000, 10'h000, 10'h000,
    10'h310, 10'h311, 10'h312, 10'h313, 10'h314, 10'h315,
    10'h100, 10'h100, 10'h100, 10'h100, 10'h100, 10'h100, 10'h100,
    10'h280,
    10'h000, 10'h000, 10'h000, 10'h000,
    10'h100,
    10'h000, 10'h000, 10'h000
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic              resp_deq_i = 1'b0;
  logic              req_ready_o, resp_valid_o;
  logic [DATA_W-1:0] resp_data_o;

  int n_chk = 0, n_fail = 0;
  int k = 0;
  int q_addr [1024];
  int q_due  [1024];
  int head = 0, tail = 0, cnt = 0;
  int n_acc = 0, n_resp = 0, win_acc = 0;
  bit prev_hold = 0;
  logic [DATA_W-1:0] prev_data = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  mrw_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT), .DEPTH(DEPTH)) u_mrw_top (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_addr_i   (req_addr_i),
    .req_ready_o  (req_ready_o),
    .resp_valid_o (resp_valid_o),
    .resp_data_o  (resp_data_o),
    .resp_deq_i   (resp_deq_i)
  );

  function automatic logic [DATA_W-1:0] exp_word(input int a);
    return DATA_W'(32'(a) * 32'h9E37 + 32'h1234);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, k);
    end
  endtask

  task automatic clear_model();
    head = 0; tail = 0; cnt = 0; prev_hold = 0;
  endtask

  // called at a negedge: drive, check, update model, advance one cycle
  task automatic step(input logic rv, input logic [ADDR_W-1:0] a, input logic dq);
    bit exp_rdy, exp_v;
    req_valid_i = rv;
    req_addr_i  = a;
    resp_deq_i  = dq;
    #1;
    exp_rdy = (cnt < DEPTH);
    exp_v   = (head != tail) && (q_due[head] <= k - 1);
    chk(req_ready_o == exp_rdy, (rv && !exp_rdy) ? "R7" : "R2", int'(req_ready_o), int'(exp_rdy));
    chk(resp_valid_o == exp_v, (dq && !exp_v) ? "R8" : "R4", int'(resp_valid_o), int'(exp_v));
    if (exp_v) begin
      chk(resp_data_o == exp_word(q_addr[head]), "R5", int'(resp_data_o), int'(exp_word(q_addr[head])));
      if (prev_hold)
        chk(resp_data_o == prev_data, "R6", int'(resp_data_o), int'(prev_data));
    end
    prev_hold = exp_v && !dq;
    prev_data = resp_data_o;
    if (rv && exp_rdy) begin
      q_addr[tail] = int'(a);
      q_due[tail]  = k + LAT;
      tail++; cnt++; n_acc++;
    end
    if (dq && exp_v) begin
      head++; cnt--; n_resp++;
      prev_hold = 0;
    end
    @(posedge clk);
    @(negedge clk);
    k++;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    #1;
    chk(req_ready_o == 1'b1, "R1", int'(req_ready_o), 1);
    chk(resp_valid_o == 1'b0, "R1", int'(resp_valid_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    clear_model();

    // table: burst past credits (R7), stall, simultaneous req+deq (R9), drain with empty deq (R8)
    for (int i = 0; i < NVEC; i++)
      step(VEC[i][9], VEC[i][7:0], VEC[i][8]);

    // drain everything, then R3: all accepted were returned in order
    for (int i = 0; i < 10; i++) step(1'b0, '0, 1'b1);
    chk(n_acc == n_resp, "R3", n_resp, n_acc);
    chk(head == tail, "R3", tail - head, 0);

    // R4: isolated request latency
    step(1'b1, 8'h5A, 1'b0);
    for (int i = 0; i < LAT + 2; i++) step(1'b0, '0, 1'b0);
    step(1'b0, '0, 1'b1);

    // R6: long stall with full buffer, then drain
    for (int i = 0; i < DEPTH; i++) step(1'b1, 8'hC0 + 8'(i), 1'b0);
    for (int i = 0; i < 150; i++) step(1'b1, 8'hEE, 1'b0);
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, '0, 1'b1);
    chk(n_acc == n_resp, "R3", n_resp, n_acc);

    // R9: request and dequeue every cycle, count accepts after warm-up
    for (int i = 0; i < 10; i++) step(1'b1, 8'(8'h20 + i), 1'b1);
    win_acc = n_acc;
    for (int i = 0; i < 30; i++) step(1'b1, 8'(8'h40 + i), 1'b1);
    chk(n_acc - win_acc == 30, "R9", n_acc - win_acc, 30);
    for (int i = 0; i < 10; i++) step(1'b0, '0, 1'b1);
    chk(n_acc == n_resp, "R3", n_resp, n_acc);

    // R1: reset with reads in flight
    step(1'b1, 8'h91, 1'b0);
    step(1'b1, 8'h92, 1'b0);
    req_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk(req_ready_o == 1'b1, "R1", int'(req_ready_o), 1);
    chk(resp_valid_o == 1'b0, "R1", int'(resp_valid_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    clear_model();
    for (int i = 0; i < LAT + 3; i++) step(1'b0, '0, 1'b0);  // nothing may appear

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule